// File: doc/BRIEF.md
# Buffered Flash Command Sequencer

This block sits between a simple register/array bus and the flash array engine. Software hands it a program, sector-erase, mass-erase or erase-verify command in three writes. The first write goes to the array itself and carries the target word address and the data. The second write puts the command code into the command register. The third write sets the buffer-empty flag to 1, which launches the command. Address, data and command sit in a one-deep buffer. From there they move into a single active-operation slot. The array engine is modelled as a down-counter whose length is a parameter for each command type.

Because there is one buffer slot behind one active slot, software can queue a second command while the first one is still running. Two flags report progress. The buffer-empty flag goes low for as long as a launched command waits in the buffer. The all-done flag goes high only when both slots are empty. Two sticky error flags, access error and protection violation, cover mis-sequenced or forbidden writes. Software clears each of them by writing 1 to it.

The sequence state machine has three states:
- `SEQ_IDLE`: no sequence is open.
- `SEQ_HAVE_ADDR`: step 1 has been taken.
- `SEQ_HAVE_CMD`: step 2 has been taken.

Its transitions:
- *take-address*: `SEQ_IDLE` to `SEQ_HAVE_ADDR`.
- *take-command*: `SEQ_HAVE_ADDR` to `SEQ_HAVE_CMD`.
- *launch*: `SEQ_HAVE_CMD` to `SEQ_IDLE`.
- *abort*: any open state back to `SEQ_IDLE`.

The engine is idle or busy. It takes a *transfer* from the buffer when it is idle, the buffer is full and no sequence is open.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status register (register offset 0) reads 0x00C0: bit 7 buffer-empty = 1, bit 6 all-done = 1, bit 5 protection violation = 0, bit 4 access error = 0. The engine is idle.
- R2: An array write to an address below ARRAY_WORDS copies the address into the address register (offset 2) and the data into the data register (offset 3). A following command write (offset 1) of code 0x20 (program), 0x40 (sector erase), 0x41 (mass erase) or 0x05 (erase verify) is readable at offset 1.
- R3: A status write with bit 7 = 1 after steps 1 and 2 clears buffer-empty and all-done on that clock edge. With the engine idle, buffer-empty returns to 1 one cycle later, and on that same edge the engine starts the buffered command (`eng_busy` = 1, `eng_cmd` = the code).
- R4: The engine stays busy for exactly PROG_CYC, SECT_CYC, MASS_CYC or VERIFY_CYC cycles, depending on the command. `eng_cmd` stays constant during that time. All-done reads 1 from the first cycle the engine is idle with the buffer empty.
- R5: A command launched while the engine is busy stays in the buffer. Buffer-empty and all-done stay 0 until the engine goes idle. The buffered command starts one cycle after that.
- R6: A new sequence begun while buffer-empty is 0 overwrites the buffered address, data and command. Only the replacement executes.
- R7: The following set access error (bit 4) and return the sequencer to `SEQ_IDLE`: a command write without step 1; a second write between steps; an invalid command code; a step-1 address at or above ARRAY_WORDS; a launch write before steps 1 and 2; a step-3 status write with bit 7 = 0; any write to offsets 2 or 3. An abort during an overwrite discards the buffered command, and buffer-empty becomes 1.
- R8: A step-1 array write with `wr_protected` high sets protection violation (bit 5), latches nothing, and leaves the sequencer idle.
- R9: Writing 1 to bit 4 or bit 5 in idle clears that flag, and writing 0 leaves it set. While either flag is set, a step-1 write latches nothing and sets access error, so no launch can happen.
- R10: Register reads and array reads during a sequence do not disturb it. Array reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 1 | 1 = register space, 0 = flash array space |
| bus_addr | input | AW | Array word address, or register offset in bits 1:0 |
| bus_wdata | input | DW | Write data |
| wr_protected | input | 1 | Array write targets a protected range (qualifies step 1) |
| bus_rdata | output | DW | Combinational read data |
| eng_busy | output | 1 | Active operation in progress |
| eng_cmd | output | 8 | Command code of the active operation |

## Verification
Every write is registered on the clock edge that samples it. Flags, hold registers and sequence state therefore change one cycle after the write, and the bench checks them at the falling edge that follows the write's edge. A transfer into the engine comes one further edge later, so `eng_busy`, `eng_cmd` and the return of buffer-empty are checked at the next falling edge. Engine length is measured by counting falling edges with `eng_busy` high, and that count is compared with the per-command cycle parameter. Status reads are combinational and are sampled inside the low clock phase, so no read crosses an edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE      = 2'd0,
        SEQ_HAVE_ADDR = 2'd1,
        SEQ_HAVE_CMD  = 2'd2
    } seq_state_t;

    localparam logic [7:0] OP_PROGRAM    = 8'h20;
    localparam logic [7:0] OP_SECT_ERASE = 8'h40;
    localparam logic [7:0] OP_MASS_ERASE = 8'h41;
    localparam logic [7:0] OP_ERASE_VFY  = 8'h05;

    localparam int ST_BUF_EMPTY = 7;
    localparam int ST_ALL_DONE  = 6;
    localparam int ST_PROT      = 5;
    localparam int ST_ACC       = 4;

    localparam logic [1:0] RO_STATUS = 2'd0;
    localparam logic [1:0] RO_CMD    = 2'd1;
    localparam logic [1:0] RO_ADDR   = 2'd2;
    localparam logic [1:0] RO_DATA   = 2'd3;

    function automatic logic op_is_valid(input logic [7:0] code);
        return (code == OP_PROGRAM) || (code == OP_SECT_ERASE) ||
               (code == OP_MASS_ERASE) || (code == OP_ERASE_VFY);
    endfunction

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int ARRAY_WORDS = 49152
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic          bus_reg,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          wr_protected,
    input  logic          xfer,
    output logic          buf_full,
    output logic          acc_err,
    output logic          prot_viol,
    output logic          seq_idle,
    output logic [AW-1:0] hold_addr,
    output logic [DW-1:0] hold_data,
    output logic [7:0]    hold_cmd
);

    localparam logic [AW:0] ADDR_LIMIT = (AW+1)'(ARRAY_WORDS);

    seq_state_t state, state_nxt;

    logic wr_any, arr_wr, reg_wr, st_wr, cmd_wr, addr_ok, err_any;
    logic set_ae, set_pv, clr_ae, clr_pv;
    logic take_addr, take_cmd, launch, drop;

    assign wr_any  = bus_en & bus_we;
    assign arr_wr  = wr_any & ~bus_reg;
    assign reg_wr  = wr_any & bus_reg;
    assign st_wr   = reg_wr && (bus_addr[1:0] == RO_STATUS);
    assign cmd_wr  = reg_wr && (bus_addr[1:0] == RO_CMD);
    assign addr_ok = {1'b0, bus_addr} < ADDR_LIMIT;
    assign err_any = acc_err | prot_viol;

    // next-state and step decisions
    always_comb begin
        state_nxt = state;
        set_ae    = 1'b0;
        set_pv    = 1'b0;
        clr_ae    = 1'b0;
        clr_pv    = 1'b0;
        take_addr = 1'b0;
        take_cmd  = 1'b0;
        launch    = 1'b0;
        drop      = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (arr_wr) begin
                    if (err_any || !addr_ok) begin
                        set_ae = 1'b1;
                    end else if (wr_protected) begin
                        set_pv = 1'b1;
                    end else begin
                        take_addr = 1'b1;
                        state_nxt = SEQ_HAVE_ADDR;
                    end
                end else if (st_wr) begin
                    set_ae = bus_wdata[ST_BUF_EMPTY];
                    clr_ae = bus_wdata[ST_ACC];
                    clr_pv = bus_wdata[ST_PROT];
                end else if (reg_wr) begin
                    set_ae = 1'b1;
                end
            end
            SEQ_HAVE_ADDR: begin
                if (cmd_wr && op_is_valid(bus_wdata[7:0])) begin
                    take_cmd  = 1'b1;
                    state_nxt = SEQ_HAVE_CMD;
                end else if (wr_any) begin
                    set_ae    = 1'b1;
                    drop      = buf_full;
                    state_nxt = SEQ_IDLE;
                end
            end
            SEQ_HAVE_CMD: begin
                if (st_wr && bus_wdata[ST_BUF_EMPTY]) begin
                    launch    = 1'b1;
                    state_nxt = SEQ_IDLE;
                end else if (wr_any) begin
                    set_ae    = 1'b1;
                    drop      = buf_full;
                    state_nxt = SEQ_IDLE;
                end
            end
            default: state_nxt = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nxt;
    end

    // outputs: flags and holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_err   <= 1'b0;
            prot_viol <= 1'b0;
            buf_full  <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
            hold_cmd  <= '0;
        end else begin
            if (set_ae)      acc_err <= 1'b1;
            else if (clr_ae) acc_err <= 1'b0;
            if (set_pv)      prot_viol <= 1'b1;
            else if (clr_pv) prot_viol <= 1'b0;
            if (launch)             buf_full <= 1'b1;
            else if (xfer || drop)  buf_full <= 1'b0;
            if (take_addr) begin
                hold_addr <= bus_addr;
                hold_data <= bus_wdata;
            end
            if (take_cmd) hold_cmd <= bus_wdata[7:0];
        end
    end

    assign seq_idle = (state == SEQ_IDLE);

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYC   = 6,
    parameter int SECT_CYC   = 20,
    parameter int MASS_CYC   = 40,
    parameter int VERIFY_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] start_cmd,
    output logic       busy,
    output logic [7:0] active_cmd
);

    localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_B = (MASS_CYC > VERIFY_CYC) ? MASS_CYC : VERIFY_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_C + 1);

    logic [CW-1:0] remain, load_len;

    always_comb begin
        unique case (start_cmd)
            OP_PROGRAM:    load_len = CW'(PROG_CYC);
            OP_SECT_ERASE: load_len = CW'(SECT_CYC);
            OP_MASS_ERASE: load_len = CW'(MASS_CYC);
            default:       load_len = CW'(VERIFY_CYC);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            remain     <= '0;
            active_cmd <= '0;
        end else if (start && !busy) begin
            busy       <= 1'b1;
            remain     <= load_len;
            active_cmd <= start_cmd;
        end else if (busy) begin
            if (remain <= CW'(1)) busy <= 1'b0;
            else                  remain <= remain - CW'(1);
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int ARRAY_WORDS = 49152,
    parameter int PROG_CYC    = 6,
    parameter int SECT_CYC    = 20,
    parameter int MASS_CYC    = 40,
    parameter int VERIFY_CYC  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic          bus_reg,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          wr_protected,
    output logic [DW-1:0] bus_rdata,
    output logic          eng_busy,
    output logic [7:0]    eng_cmd
);

    logic          buf_full, acc_err, prot_viol, seq_idle, xfer;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;
    logic [7:0]    hold_cmd;
    logic [DW-1:0] status_word;

    assign xfer = buf_full & ~eng_busy & seq_idle;

    flash_seq_ctrl #(.AW(AW), .DW(DW), .ARRAY_WORDS(ARRAY_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_reg(bus_reg),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wr_protected(wr_protected), .xfer(xfer),
        .buf_full(buf_full), .acc_err(acc_err), .prot_viol(prot_viol),
        .seq_idle(seq_idle), .hold_addr(hold_addr), .hold_data(hold_data),
        .hold_cmd(hold_cmd)
    );

    flash_op_engine #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
                      .MASS_CYC(MASS_CYC), .VERIFY_CYC(VERIFY_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(xfer), .start_cmd(hold_cmd),
        .busy(eng_busy), .active_cmd(eng_cmd)
    );

    always_comb begin
        status_word               = '0;
        status_word[ST_BUF_EMPTY] = ~buf_full;
        status_word[ST_ALL_DONE]  = ~buf_full & ~eng_busy;
        status_word[ST_PROT]      = prot_viol;
        status_word[ST_ACC]       = acc_err;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we && bus_reg) begin
            unique case (bus_addr[1:0])
                RO_STATUS: bus_rdata = status_word;
                RO_CMD:    bus_rdata = DW'(hold_cmd);
                RO_ADDR:   bus_rdata = DW'(hold_addr);
                default:   bus_rdata = hold_data;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
    import flash_cmd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_en,
    input logic          bus_we,
    input logic          bus_reg,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          buf_full,
    input logic          acc_err,
    input logic          prot_viol,
    input logic          seq_idle,
    input logic          eng_busy,
    input logic [7:0]    eng_cmd
);

    logic ae_clear_wr;
    assign ae_clear_wr = bus_en && bus_we && bus_reg &&
                         (bus_addr[1:0] == RO_STATUS) && bus_wdata[ST_ACC];

    p_transfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && !eng_busy && seq_idle |=> eng_busy && !buf_full);

    p_start_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> op_is_valid(eng_cmd));

    p_cmd_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy && $past(eng_busy) |-> $stable(eng_cmd));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err && !ae_clear_wr |=> acc_err);

    p_no_fill_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err || prot_viol) && !buf_full |=> !buf_full);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_reg(bus_reg), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .buf_full(buf_full), .acc_err(acc_err), .prot_viol(prot_viol),
    .seq_idle(seq_idle), .eng_busy(eng_busy), .eng_cmd(eng_cmd)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int ARRAY_WORDS = 49152;
    localparam int PROG_CYC = 6, SECT_CYC = 20, MASS_CYC = 40, VERIFY_CYC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0, bus_reg = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          wr_protected = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          eng_busy;
    logic [7:0]    eng_cmd;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq #(.AW(AW), .DW(DW), .ARRAY_WORDS(ARRAY_WORDS),
        .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .MASS_CYC(MASS_CYC),
        .VERIFY_CYC(VERIFY_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_reg(bus_reg), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wr_protected(wr_protected), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_cmd(eng_cmd)
    );

    function automatic bit code_ok(input logic [7:0] c);
        return c == 8'h20 || c == 8'h40 || c == 8'h41 || c == 8'h05;
    endfunction

    function automatic int op_len(input logic [7:0] c);
        case (c)
            8'h20:   return PROG_CYC;
            8'h40:   return SECT_CYC;
            8'h41:   return MASS_CYC;
            default: return VERIFY_CYC;
        endcase
    endfunction

    function automatic logic [15:0] stat_word(input bit be, cd, pv, ae);
        return {8'h00, be, cd, pv, ae, 4'h0};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic check_eq(input string req, input logic [31:0] got,
                            input logic [31:0] exp);
        check(got === exp, req, got, exp);
    endtask

    // zero-time read inside the low phase
    task automatic rd(input logic isreg, input logic [AW-1:0] a,
                      output logic [DW-1:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_reg = isreg; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    // one-cycle write, returns at the falling edge after the sampling edge
    task automatic wr(input logic isreg, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic prot);
        bus_en = 1'b1; bus_we = 1'b1; bus_reg = isreg; bus_addr = a;
        bus_wdata = d; wr_protected = prot;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; wr_protected = 1'b0;
    endtask

    task automatic do_seq(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [7:0] c);
        wr(1'b0, a, d, 1'b0);
        wr(1'b1, 16'd1, {8'h00, c}, 1'b0);
        wr(1'b1, 16'd0, 16'h0080, 1'b0);
    endtask

    // at a falling edge where the engine has just started: count busy cycles
    task automatic count_busy(output int n);
        n = 0;
        while (eng_busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        while (eng_busy) @(negedge clk);
    endtask

    task automatic clear_errs();
        wr(1'b1, 16'd0, 16'h0030, 1'b0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R4: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] s;
        int n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b1, 16'd0, s);
        check_eq("R1 status after reset", s, stat_word(1, 1, 0, 0));
        check_eq("R1 engine idle", eng_busy, 0);

        // R2 / R10 latch and reads mid-sequence
        wr(1'b0, 16'h0123, 16'hBEEF, 1'b0);
        rd(1'b0, 16'h0123, s);
        check_eq("R10 array read returns 0", s, 16'h0000);
        rd(1'b1, 16'd0, s);
        check_eq("R10 status during sequence", s, stat_word(1, 1, 0, 0));
        wr(1'b1, 16'd1, 16'h0020, 1'b0);
        rd(1'b1, 16'd2, s);
        check_eq("R2 address register", s, 16'h0123);
        rd(1'b1, 16'd3, s);
        check_eq("R2 data register", s, 16'hBEEF);
        rd(1'b1, 16'd1, s);
        check_eq("R2 command register", s, 16'h0020);
        wr(1'b1, 16'd0, 16'h0080, 1'b0);
        rd(1'b1, 16'd0, s);
        check_eq("R3 flags cleared on launch", s, stat_word(0, 0, 0, 0));
        @(negedge clk);
        rd(1'b1, 16'd0, s);
        check_eq("R3 buffer empty again", s, stat_word(1, 0, 0, 0));
        check_eq("R3 engine started", eng_busy, 1);
        check_eq("R3 engine command", eng_cmd, 8'h20);
        count_busy(n);
        check_eq("R4 program length", n, PROG_CYC);
        rd(1'b1, 16'd0, s);
        check_eq("R4 all done", s, stat_word(1, 1, 0, 0));

        // R5 buffered command behind active one
        do_seq(16'h0010, 16'h1234, 8'h20);
        do_seq(16'h0020, 16'h0000, 8'h05);
        rd(1'b1, 16'd0, s);
        check_eq("R5 buffer held while busy", s, stat_word(0, 0, 0, 0));
        wait_idle();
        rd(1'b1, 16'd0, s);
        check_eq("R5 still buffered at first idle cycle", s, stat_word(0, 0, 0, 0));
        @(negedge clk);
        check_eq("R5 buffered command starts", eng_busy, 1);
        check_eq("R5 buffered command code", eng_cmd, 8'h05);
        count_busy(n);
        check_eq("R5 verify length", n, VERIFY_CYC);

        // R6 overwrite of a buffered command
        do_seq(16'h0000, 16'h0000, 8'h41);
        do_seq(16'h0100, 16'h2222, 8'h40);
        do_seq(16'h0200, 16'h1111, 8'h20);
        rd(1'b1, 16'd2, s);
        check_eq("R6 address replaced", s, 16'h0200);
        wait_idle();
        @(negedge clk);
        check_eq("R6 replacement command runs", eng_cmd, 8'h20);
        count_busy(n);
        check_eq("R6 replacement length", n, PROG_CYC);
        @(negedge clk);
        rd(1'b1, 16'd0, s);
        check_eq("R6 nothing else queued", s, stat_word(1, 1, 0, 0));

        // R7 access errors
        wr(1'b1, 16'd0, 16'h0080, 1'b0);
        rd(1'b1, 16'd0, s);
        check_eq("R7 launch without steps", s, stat_word(1, 1, 0, 1));
        clear_errs();
        rd(1'b1, 16'd0, s);
        check_eq("R9 clear by writing one", s, stat_word(1, 1, 0, 0));
        wr(1'b1, 16'd1, 16'h0020, 1'b0);
        rd(1'b1, 16'd0, s);
        check_eq("R7 command before address", s, stat_word(1, 1, 0, 1));
        wr(1'b1, 16'd0, 16'h0000, 1'b0);
        rd(1'b1, 16'd0, s);
        check_eq("R9 writing zero keeps flag", s, stat_word(1, 1, 0, 1));
        clear_errs();
        wr(1'b0, 16'h0300, 16'h0, 1'b0);
        wr(1'b1, 16'd1, 16'h0033, 1'b0);
        rd(1'b1, 16'd0, s);
        check_eq("R7 invalid code", s, stat_word(1, 1, 0, 1));
        clear_errs();
        wr(1'b0, 16'hC000, 16'h0, 1'b0);
        rd(1'b1, 16'd0, s);
        check_eq("R7 address out of range", s, stat_word(1, 1, 0, 1));
        rd(1'b1, 16'd2, s);
        check_eq("R7 out-of-range address not latched", s, 16'h0300);
        clear_errs();
        wr(1'b0, 16'h0004, 16'h0, 1'b0);
        wr(1'b0, 16'h0005, 16'h0, 1'b0);
        rd(1'b1, 16'd0, s);
        check_eq("R7 second array write", s, stat_word(1, 1, 0, 1));
        clear_errs();
        wr(1'b0, 16'h0006, 16'h0, 1'b0);
        wr(1'b1, 16'd1, 16'h0040, 1'b0);
        wr(1'b1, 16'd0, 16'h0000, 1'b0);
        @(negedge clk);
        rd(1'b1, 16'd0, s);
        check_eq("R7 step three with zero", s, stat_word(1, 1, 0, 1));
        check_eq("R7 no start after bad step three", eng_busy, 0);
        clear_errs();
        do_seq(16'h0000, 16'h0, 8'h41);
        do_seq(16'h0100, 16'h0, 8'h40);
        wr(1'b0, 16'h0200, 16'h0, 1'b0);
        wr(1'b1, 16'd2, 16'h0, 1'b0);
        rd(1'b1, 16'd0, s);
        check_eq("R7 abort drops buffered command", s, stat_word(1, 0, 0, 1));
        wait_idle();
        @(negedge clk);
        @(negedge clk);
        check_eq("R7 dropped command never runs", eng_busy, 0);
        clear_errs();

        // R8 protection violation
        wr(1'b0, 16'h0400, 16'h5555, 1'b1);
        rd(1'b1, 16'd0, s);
        check_eq("R8 protection flag", s, stat_word(1, 1, 1, 0));
        rd(1'b1, 16'd2, s);
        check_eq("R8 nothing latched", s, 16'h0200);
        wr(1'b1, 16'd1, 16'h0020, 1'b0);
        rd(1'b1, 16'd0, s);
        check_eq("R8 sequencer stayed idle", s, stat_word(1, 1, 1, 1));

        // R9 error blocks new sequences
        wr(1'b0, 16'h0500, 16'h0, 1'b0);
        wr(1'b1, 16'd1, 16'h0020, 1'b0);
        wr(1'b1, 16'd0, 16'h0080, 1'b0);
        @(negedge clk);
        check_eq("R9 no launch while flagged", eng_busy, 0);
        rd(1'b1, 16'd2, s);
        check_eq("R9 step one refused", s, 16'h0200);
        clear_errs();
        rd(1'b1, 16'd0, s);
        check_eq("R9 both flags cleared", s, stat_word(1, 1, 0, 0));

        // random mix, R2 R4 R7
        for (int i = 0; i < 24; i++) begin
            logic [7:0] c;
            logic [AW-1:0] a;
            int pick;
            pick = int'($urandom % 5);
            case (pick)
                0: c = 8'h20;
                1: c = 8'h40;
                2: c = 8'h41;
                3: c = 8'h05;
                default: begin
                    c = 8'($urandom);
                    while (code_ok(c)) c = c + 8'd1;
                end
            endcase
            a = AW'($urandom % ARRAY_WORDS);
            do_seq(a, 16'($urandom), c);
            if (code_ok(c)) begin
                @(negedge clk);
                check_eq("R2 random command started", eng_cmd, 32'(c));
                count_busy(n);
                check_eq("R4 random length", n, op_len(c));
                rd(1'b1, 16'd0, s);
                check_eq("R4 random all done", s, stat_word(1, 1, 0, 0));
            end else begin
                rd(1'b1, 16'd0, s);
                check_eq("R7 random invalid code", s, stat_word(1, 1, 0, 1));
                clear_errs();
            end
        end

        finish_run();
    end

endmodule